// File: doc/BRIEF.md
# DAC Load Advance Timer

This block places the DAC load strobe inside every sampling interval. It counts DMCLK ticks from the sample-rate strobe. It raises the ADC-ready frame-sync flag at a fixed phase in the interval. It then works backwards from that flag to find where the DAC load must fall. With no advance, the load lands one serial clock period ahead of the flag. Each unit of the 5-bit advance field moves the load a further 1/32 of the sample period earlier. The position wraps modulo the sample period, so a large advance can place the load late in the same interval.

The advance field is held in a local register. A write reaches that register only while the DAC is powered down, and a write made while the DAC is powered is dropped. The sample period and the serial clock period are set by two rate selects. These selects are treated as static while the timer runs.

Top module: `dac_load_timer`

## Requirements
- R1: After reset, both outputs are low and the advance value is 0. No pulse appears on either output until the first tick that carries the sample strobe.
- R2: The sample period P in DMCLK ticks is set by rate_sel_i: 2'b00 gives 2048, 2'b01 gives 1024, 2'b10 gives 512 and 2'b11 gives 256. A tick with samp_strobe_i high is phase 0. Without a strobe, the phase counts up and wraps from P-1 to 0, and a strobe in mid-interval resets it to phase 0.
- R3: adc_fs_o pulses exactly once per interval, on the tick whose phase equals FS_OFS (default 64).
- R4: With an advance of 0, dac_load_o pulses on the tick whose phase is FS_OFS minus the serial period. sclk_sel_i selects that period: 2'b00 gives 8 ticks, 2'b01 gives 4, 2'b10 gives 2 and 2'b11 gives 1.
- R5: Each unit of the 5-bit advance moves the load P/32 ticks earlier. The load phase is (FS_OFS - serial period - advance*P/32) mod P.
- R6: A pulse on adv_wr_i loads adv_data_i[4:0] as the advance only while dac_pwr_i is low. While dac_pwr_i is high the write is ignored and the previous advance stays in use.
- R7: Each output is a single-clock pulse that appears only in the clock after a DMCLK tick. dac_load_o pulses exactly once per interval.
- R8: While dmclk_en_i is low the phase holds, so positions are counted in DMCLK ticks and not in clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dmclk_en_i | input | 1 | Internal master clock tick enable |
| samp_strobe_i | input | 1 | Start of sampling interval, qualified by dmclk_en_i |
| rate_sel_i | input | 2 | Sample period select |
| sclk_sel_i | input | 2 | Serial clock period select |
| adv_wr_i | input | 1 | Advance field write strobe |
| adv_data_i | input | 5 | Advance value to write |
| dac_pwr_i | input | 1 | DAC powered up; blocks advance writes |
| dac_load_o | output | 1 | DAC load strobe |
| adc_fs_o | output | 1 | ADC data-ready frame sync |

## Verification
The assertions check, on every cycle, the properties that hold at any instant. Both outputs must be single-clock pulses. Any pulse must follow a DMCLK tick. The held advance must not change while the DAC is powered. The bench scenarios cover what the assertions cannot. These are the actual load and frame-sync phases for each rate select, serial select and advance value, including the wrap case where the load falls after the frame sync. The scenarios also show that a write blocked by the power flag has no effect, that the counter realigns on a mid-interval strobe and runs freely without one, and that counting holds through gaps in the DMCLK enable.

// File: rtl/dla_pkg.sv
package dla_pkg;
  typedef enum logic [1:0] {
    RATE_X8 = 2'b00,
    RATE_X4 = 2'b01,
    RATE_X2 = 2'b10,
    RATE_X1 = 2'b11
  } rate_sel_e;

  typedef enum logic [1:0] {
    SCK_DIV8 = 2'b00,
    SCK_DIV4 = 2'b01,
    SCK_DIV2 = 2'b10,
    SCK_DIV1 = 2'b11
  } sclk_sel_e;

  localparam int unsigned NUM_EV = 2;
  localparam int unsigned EV_FS  = 0;
  localparam int unsigned EV_LD  = 1;
endpackage

// File: rtl/dla_adv_reg.sv
module dla_adv_reg #(
  parameter int unsigned ADV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [ADV_W-1:0] data_i,
  input  logic             lock_i,
  output logic [ADV_W-1:0] adv_o
);
  logic [ADV_W-1:0] adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             adv_q <= '0;
    else if (wr_i && !lock_i) adv_q <= data_i;
  end

  assign adv_o = adv_q;
endmodule

// File: rtl/dla_phase_ctr.sv
module dla_phase_ctr #(
  parameter int unsigned PH_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            strobe_i,
  input  logic [PH_W-1:0] per_m1_i,
  output logic [PH_W-1:0] phase_o,
  output logic            run_o
);
  logic [PH_W-1:0] phase_q;
  logic            run_q;
  logic [PH_W-1:0] cur;

  // strobe tick is phase 0 of the new interval
  assign cur = strobe_i ? '0 : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else if (tick_i) begin
      phase_q <= (cur >= per_m1_i) ? '0 : cur + 1'b1;
      if (strobe_i) run_q <= 1'b1;
    end
  end

  assign phase_o = cur;
  assign run_o   = run_q || strobe_i;
endmodule

// File: rtl/dla_event_dec.sv
module dla_event_dec
  import dla_pkg::*;
#(
  parameter int unsigned PH_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic [PH_W-1:0] pos_i [NUM_EV],
  output logic            pulse_o [NUM_EV]
);
  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    logic hit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hit_q <= 1'b0;
      else         hit_q <= tick_i && run_i && (phase_i == pos_i[e]);
    end
    assign pulse_o[e] = hit_q;
  end
endmodule

// File: rtl/dac_load_timer.sv
module dac_load_timer
  import dla_pkg::*;
#(
  parameter int unsigned BASE_DIV = 256,
  parameter int unsigned SLOTS    = 32,
  parameter int unsigned ADV_W    = 5,
  parameter int unsigned SCK_MAX  = 8,
  parameter int unsigned FS_OFS   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dmclk_en_i,
  input  logic             samp_strobe_i,
  input  logic [1:0]       rate_sel_i,
  input  logic [1:0]       sclk_sel_i,
  input  logic             adv_wr_i,
  input  logic [ADV_W-1:0] adv_data_i,
  input  logic             dac_pwr_i,
  output logic             dac_load_o,
  output logic             adc_fs_o
);
  localparam int unsigned MAX_PER = BASE_DIV * 8;
  localparam int unsigned PH_W    = $clog2(MAX_PER);
  localparam int unsigned SLOT_SH = $clog2(SLOTS);

  logic [ADV_W-1:0] adv_q;
  logic [PH_W:0]    period;
  logic [PH_W-1:0]  per_m1;
  logic [PH_W-1:0]  slot_len;
  logic [PH_W-1:0]  sck_per;
  logic [PH_W-1:0]  ld_raw;
  logic [PH_W-1:0]  phase;
  logic             run;
  logic [PH_W-1:0]  pos   [NUM_EV];
  logic             pulse [NUM_EV];

  dla_adv_reg #(.ADV_W(ADV_W)) u_adv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (adv_wr_i),
    .data_i (adv_data_i),
    .lock_i (dac_pwr_i),
    .adv_o  (adv_q)
  );

  // 2'b00 is the slowest rate
  assign period   = (PH_W+1)'(BASE_DIV) << (2'd3 - rate_sel_i);
  assign per_m1   = PH_W'(period - 1'b1);
  assign slot_len = PH_W'(period >> SLOT_SH);
  assign sck_per  = PH_W'(SCK_MAX) >> sclk_sel_i;

  // modular back-off from the frame-sync phase; P divides 2^PH_W
  assign ld_raw = PH_W'(FS_OFS) - sck_per - PH_W'(adv_q * slot_len);

  assign pos[EV_FS] = PH_W'(FS_OFS);
  assign pos[EV_LD] = ld_raw & per_m1;

  dla_phase_ctr #(.PH_W(PH_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (dmclk_en_i),
    .strobe_i (samp_strobe_i),
    .per_m1_i (per_m1),
    .phase_o  (phase),
    .run_o    (run)
  );

  dla_event_dec #(.PH_W(PH_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (dmclk_en_i),
    .run_i   (run),
    .phase_i (phase),
    .pos_i   (pos),
    .pulse_o (pulse)
  );

  assign adc_fs_o   = pulse[EV_FS];
  assign dac_load_o = pulse[EV_LD];
endmodule

// File: rtl/dac_load_timer_chk.sv
module dac_load_timer_chk #(
  parameter int unsigned ADV_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dmclk_en_i,
  input logic             dac_pwr_i,
  input logic             dac_load_o,
  input logic             adc_fs_o,
  input logic [ADV_W-1:0] adv_q
);
  p_fs_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_fs_o |=> !adc_fs_o);

  p_load_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_load_o |=> !dac_load_o);

  p_fs_after_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_fs_o) |-> $past(dmclk_en_i));

  p_load_after_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_load_o) |-> $past(dmclk_en_i));

  p_adv_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_pwr_i |=> $stable(adv_q));
endmodule

bind dac_load_timer dac_load_timer_chk #(.ADV_W(ADV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dmclk_en_i (dmclk_en_i),
  .dac_pwr_i  (dac_pwr_i),
  .dac_load_o (dac_load_o),
  .adc_fs_o   (adc_fs_o),
  .adv_q      (adv_q)
);

// File: tb/dac_load_timer_bench.sv
module dac_load_timer_bench;
  localparam int FS_OFS = 64;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dmclk_en_i = 1'b0;
  logic       samp_strobe_i = 1'b0;
  logic [1:0] rate_sel_i = 2'b11;
  logic [1:0] sclk_sel_i = 2'b00;
  logic       adv_wr_i = 1'b0;
  logic [4:0] adv_data_i = '0;
  logic       dac_pwr_i = 1'b0;
  logic       dac_load_o;
  logic       adc_fs_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  dac_load_timer u_dac_load_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dmclk_en_i    (dmclk_en_i),
    .samp_strobe_i (samp_strobe_i),
    .rate_sel_i    (rate_sel_i),
    .sclk_sel_i    (sclk_sel_i),
    .adv_wr_i      (adv_wr_i),
    .adv_data_i    (adv_data_i),
    .dac_pwr_i     (dac_pwr_i),
    .dac_load_o    (dac_load_o),
    .adc_fs_o      (adc_fs_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int per_of(input int rs);
    return 2048 >> rs;
  endfunction

  function automatic int exp_load(input int rs, input int ss, input int adv);
    int p = per_of(rs);
    int v = FS_OFS - (8 >> ss) - adv * (p / 32);
    return ((v % p) + p) % p;
  endfunction

  task automatic write_adv(input int val, input bit pwr);
    dac_pwr_i  = pwr;
    adv_wr_i   = 1'b1;
    adv_data_i = 5'(val);
    @(negedge clk_i);
    adv_wr_i   = 1'b0;
    @(negedge clk_i);
    dac_pwr_i  = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      dmclk_en_i    = 1'b1;
      samp_strobe_i = (k == 0);
      @(negedge clk_i);
      dmclk_en_i    = 1'b0;
      samp_strobe_i = 1'b0;
    end
  endtask

  // one full interval; outputs seen at negedge k reflect tick phase k
  task automatic run_interval(input int rs, input int ss, input int adv,
                              input int gap, input bit strobe, input string tag);
    int p = per_of(rs);
    int fs_at = -1, ld_at = -1, nfs = 0, nld = 0, bad = 0;
    rate_sel_i = 2'(rs);
    sclk_sel_i = 2'(ss);
    for (int k = 0; k < p; k++) begin
      dmclk_en_i    = 1'b1;
      samp_strobe_i = strobe && (k == 0);
      @(negedge clk_i);
      dmclk_en_i    = 1'b0;
      samp_strobe_i = 1'b0;
      if (adc_fs_o)   begin nfs++; fs_at = k; end
      if (dac_load_o) begin nld++; ld_at = k; end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk_i);
        if (adc_fs_o || dac_load_o) bad++;
      end
    end
    check(fs_at == FS_OFS, {"R3 fs phase ", tag}, fs_at, FS_OFS);
    check(nfs == 1, {"R3 fs count ", tag}, nfs, 1);
    check(ld_at == exp_load(rs, ss, adv), {"R5 load phase ", tag}, ld_at, exp_load(rs, ss, adv));
    check(nld == 1, {"R7 load count ", tag}, nld, 1);
    if (gap > 0) check(bad == 0, {"R8 idle gap pulses ", tag}, bad, 0);
  endtask

  task automatic t_reset;
    int n = 0;
    check(!adc_fs_o && !dac_load_o, "R1 outputs after reset", {adc_fs_o, dac_load_o}, 0);
    for (int k = 0; k < 20; k++) begin
      dmclk_en_i = 1'b1;
      @(negedge clk_i);
      if (adc_fs_o || dac_load_o) n++;
    end
    dmclk_en_i = 1'b0;
    check(n == 0, "R1 no pulse before first strobe", n, 0);
  endtask

  task automatic t_zero_adv;
    run_interval(3, 0, 0, 0, 1'b1, "R4 zero advance div8");
    run_interval(3, 1, 0, 0, 1'b1, "R4 zero advance div4");
  endtask

  task automatic t_adv_steps;
    write_adv(5, 1'b0);
    run_interval(3, 1, 5, 0, 1'b1, "R5 adv5 P256");
    write_adv(31, 1'b0);
    run_interval(3, 3, 31, 0, 1'b1, "R5 adv31 wrap");
    write_adv(3, 1'b0);
    run_interval(0, 2, 3, 0, 1'b1, "R2 P2048 adv3");
  endtask

  task automatic t_locked;
    write_adv(9, 1'b1);
    run_interval(2, 2, 3, 0, 1'b1, "R6 write ignored while powered");
    write_adv(9, 1'b0);
    run_interval(2, 2, 9, 0, 1'b1, "R6 write taken while off");
  endtask

  task automatic t_gap;
    write_adv(2, 1'b0);
    run_interval(3, 0, 2, 1, 1'b1, "R8 half-rate ticks");
  endtask

  task automatic t_realign;
    rate_sel_i = 2'b11;
    ticks(100);
    run_interval(3, 0, 2, 0, 1'b1, "R2 realign on strobe");
    run_interval(3, 0, 2, 0, 1'b0, "R2 free-run wrap");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_zero_adv();
    t_adv_steps();
    t_locked();
    t_gap();
    t_realign();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule